// File: doc/BRIEF.md
# Paged Descriptor Ring Address Generator

This block produces memory addresses for three circular descriptor rings shared between a device and its driver. The device consumes entries from a request ring and produces entries into a completion ring and a message ring. No ring occupies contiguous memory. Each one is a list of pages, and software loads a small page table of frame numbers for it. A ring index is therefore split into a page-table lookup and an offset inside that page.

Software loads the page table, then issues a setup with a page count. The block derives the ring's size and index mask from that count, clears the ring's pointers, and emits a status-page write that zeroes both indices and records the size exponent. A pop returns the address of the next slot, or reports that no slot is available. A flush emits a status-page write that publishes the device-side index. The three rings follow different availability rules. A request slot exists only when the producer has moved ahead. A completion slot is always granted. A message slot needs free room as seen by the consumer. Every output is registered and appears on the clock edge after the operation is presented.

Top module: `ring_addr_gen`

## Requirements
- R1: Reset, and a cleanup pulse (`clr_en`, which overrides every other operation in its cycle), leave all three rings unconfigured and zero every page table. A pop on an unconfigured ring answers `rsp_valid`=1, `rsp_hit`=0, `rsp_addr`=0. A flush on an unconfigured ring produces no status write.
- R2: Setup is accepted only when the page count is a power of two from 1 to MAX_PAGES. An accepted setup zeroes the ring's pointers and produces, one cycle later, a status write with `st_prod_we`=`st_cons_we`=`st_log2_we`=1, `st_idx`=0, `st_ring` equal to the ring, and `st_log2` = floor(log2(pages*entries_per_page - 1)) + 1. A rejected count produces no write and leaves the ring as it was.
- R3: Ring codes are 0 request, 1 completion and 2 message. Descriptors are 128, 32 and 64 bytes, and a page is 4096 bytes, so a page holds 32, 128 or 64 entries. A granted pop uses slot = pointer AND mask, page = slot / entries, offset = slot % entries, and returns address = (frame[page] << 12) + offset * descriptor size. The pointer then advances by one.
- R4: A request pop is granted only when `req_prod_idx` differs from the consumed pointer. Otherwise it answers hit 0 with address 0 and the pointer does not move.
- R5: A request flush writes `st_cons_we`=1, `st_prod_we`=0 and `st_idx` = the consumed pointer.
- R6: A completion pop on a configured ring is always granted. There is no overflow check, and the slot wraps to 0 after capacity pops.
- R7: A completion flush writes `st_prod_we`=1, `st_cons_we`=0 and `st_idx` = the fill pointer.
- R8: A message pop is granted only when (published producer index - `msg_cons_idx`) modulo 2^32 is below the ring capacity. A refused pop answers hit 0, address 0, and the pointer does not move.
- R9: A message flush writes `st_prod_we`=1 with `st_idx` = the fill pointer. The published value becomes the producer index used by R8.
- R10: In a cycle with `setup_en`, a pop or a flush presented on any ring is dropped. It gives no response, no status write, and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_en | input | 1 | Cleanup of all rings and page tables |
| pt_we | input | 1 | Page table write strobe |
| pt_ring | input | 2 | Ring whose page table is written |
| pt_slot | input | PG_W | Page table entry index |
| pt_pfn | input | ADDR_W-PAGE_SHIFT | Page frame number to store |
| setup_en | input | 1 | Ring setup strobe |
| setup_ring | input | 2 | Ring being set up |
| setup_pages | input | CNT_W | Page count for the setup |
| pop_en | input | 1 | Pop strobe |
| pop_ring | input | 2 | Ring to pop |
| flush_en | input | 1 | Flush strobe |
| flush_ring | input | 2 | Ring to flush |
| req_prod_idx | input | 32 | Request producer index from the status page |
| msg_cons_idx | input | 32 | Message consumer index from the status page |
| rsp_valid | output | 1 | A pop was answered |
| rsp_hit | output | 1 | The pop was granted a slot |
| rsp_ring | output | 2 | Ring of the answered pop |
| rsp_addr | output | ADDR_W | Slot address, 0 when not granted |
| st_prod_we | output | 1 | Status write of the producer index |
| st_cons_we | output | 1 | Status write of the consumer index |
| st_log2_we | output | 1 | Status write of the size exponent |
| st_ring | output | 2 | Ring of the status write |
| st_idx | output | 32 | Index value to write |
| st_log2 | output | 6 | Size exponent to write |

## Verification
Request pops are run with the producer index equal to the consumed pointer, then moved ahead by forty slots, then moved past the ring end. These runs separate a refused pop from a granted one and show the page switch from the first frame to the second and the wrap back to slot 0. The completion ring is popped past its capacity, which shows that no overflow check exists and that the slot index wraps. Message pops are tried with consumer indices just inside and just outside the room window, across the 32-bit wrap of the subtraction. Setup is tried with invalid page counts, and together with a pop and a flush in the same cycle, to show what it rejects and what it overrides.

// File: rtl/rag_pkg.sv
package rag_pkg;

    localparam int IDX_W = 32;
    localparam int LOG_W = 6;

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        RING_REQ = 2'd0,
        RING_CMP = 2'd1,
        RING_MSG = 2'd2,
        RING_NONE = 2'd3
    } ring_e;

    typedef struct packed {
        logic             prod_we;
        logic             cons_we;
        logic             log2_we;
        ring_e            ring;
        idx_t             idx;
        logic [LOG_W-1:0] log2;
    } stat_wr_t;

    // floor(log2(cap - 1)) + 1
    function automatic logic [LOG_W-1:0] size_log2(input logic [IDX_W:0] cap);
        logic [IDX_W:0]   v;
        logic [LOG_W-1:0] r;
        v = cap - (IDX_W+1)'(1);
        r = '0;
        for (int b = 0; b <= IDX_W; b++) begin
            if (v[b]) r = LOG_W'(b + 1);
        end
        return r;
    endfunction

    function automatic idx_t len_mask(input logic [LOG_W-1:0] l2);
        idx_t m;
        m = '0;
        for (int b = 0; b < IDX_W; b++) begin
            if (LOG_W'(b) < l2) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rag_pgtab.sv
module rag_pgtab
    import rag_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int MAX_PAGES  = 8,
    parameter int EPP_LOG2   = 5,
    parameter int DESC_LOG2  = 7,
    localparam int PFN_W     = ADDR_W - PAGE_SHIFT,
    localparam int PG_W      = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [PG_W-1:0]   wslot,
    input  logic [PFN_W-1:0]  wpfn,
    input  idx_t              slot,
    output logic [PG_W-1:0]   page_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic [PFN_W-1:0]    frames [MAX_PAGES];
    logic [EPP_LOG2-1:0] offset;
    logic [ADDR_W-1:0]   base;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int p = 0; p < MAX_PAGES; p++) frames[p] <= '0;
        end else if (we && (int'(wslot) < MAX_PAGES)) begin
            frames[wslot] <= wpfn;
        end
    end

    always_comb begin
        page_o = PG_W'(slot >> EPP_LOG2);
        offset = slot[EPP_LOG2-1:0];
        base   = {frames[page_o], {PAGE_SHIFT{1'b0}}};
        addr_o = base + (ADDR_W'(offset) << DESC_LOG2);
    end

endmodule

// File: rtl/rag_lane.sv
module rag_lane
    import rag_pkg::*;
#(
    parameter ring_e KIND       = RING_REQ,
    parameter int    ADDR_W     = 64,
    parameter int    PAGE_SHIFT = 12,
    parameter int    MAX_PAGES  = 8,
    parameter int    DESC_BYTES = 128,
    localparam int   PFN_W      = ADDR_W - PAGE_SHIFT,
    localparam int   PG_W       = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1,
    localparam int   CNT_W      = $clog2(MAX_PAGES + 1),
    localparam int   EPP        = (1 << PAGE_SHIFT) / DESC_BYTES,
    localparam int   EPP_LOG2   = $clog2(EPP),
    localparam int   DESC_LOG2  = $clog2(DESC_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              setup_i,
    input  logic [CNT_W-1:0]  setup_pages_i,
    input  logic              pt_we_i,
    input  logic [PG_W-1:0]   pt_slot_i,
    input  logic [PFN_W-1:0]  pt_pfn_i,
    input  logic              pop_i,
    input  logic              flush_i,
    input  idx_t              peer_idx_i,
    output logic              cfg_o,
    output logic              setup_ok_o,
    output logic [LOG_W-1:0]  new_log2_o,
    output idx_t              ptr_o,
    output logic              pop_ok_o,
    output logic [ADDR_W-1:0] pop_addr_o
);

    logic             cfg_q;
    idx_t             ptr_q;
    idx_t             pub_q;
    idx_t             mask_q;
    logic [CNT_W-1:0] cnt_q;

    logic             pow2;
    logic [IDX_W:0]   cap;
    logic             ahead;
    idx_t             occ;
    logic             room;
    logic             avail;
    logic [PG_W-1:0]  page;

    // setup validation and size computation
    always_comb begin
        pow2 = (setup_pages_i != '0) &&
               ((setup_pages_i & (setup_pages_i - CNT_W'(1))) == '0) &&
               (int'(setup_pages_i) <= MAX_PAGES);
        setup_ok_o = setup_i && pow2;
        cap        = (IDX_W+1)'(setup_pages_i) << EPP_LOG2;
        new_log2_o = size_log2(cap);
    end

    // slot availability, one rule per ring kind
    always_comb begin
        ahead = (peer_idx_i != ptr_q);
        occ   = pub_q - peer_idx_i;
        room  = ({1'b0, occ} < ({1'b0, mask_q} + (IDX_W+1)'(1)));
        case (KIND)
            RING_REQ: avail = ahead;
            RING_MSG: avail = room;
            default:  avail = 1'b1;
        endcase
        pop_ok_o = cfg_q && pop_i && avail;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cfg_q  <= 1'b0;
            ptr_q  <= '0;
            pub_q  <= '0;
            mask_q <= '0;
            cnt_q  <= '0;
        end else if (setup_ok_o) begin
            cfg_q  <= 1'b1;
            ptr_q  <= '0;
            pub_q  <= '0;
            mask_q <= len_mask(new_log2_o);
            cnt_q  <= setup_pages_i;
        end else begin
            if (pop_ok_o) ptr_q <= ptr_q + idx_t'(1);
            if (flush_i && cfg_q) pub_q <= ptr_q;
        end
    end

    rag_pgtab #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .MAX_PAGES  (MAX_PAGES),
        .EPP_LOG2   (EPP_LOG2),
        .DESC_LOG2  (DESC_LOG2)
    ) u_pgtab (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .we     (pt_we_i),
        .wslot  (pt_slot_i),
        .wpfn   (pt_pfn_i),
        .slot   (ptr_q & mask_q),
        .page_o (page),
        .addr_o (pop_addr_o)
    );

    assign cfg_o = cfg_q;
    assign ptr_o = ptr_q;

    AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (rst)
        pop_ok_o |-> (CNT_W'(page) < cnt_q)); // R3

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (pop_ok_o && !clr) |=> (ptr_q == $past(ptr_q) + idx_t'(1))); // R6

    AST_SETUP_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (setup_ok_o && !clr) |=> (cfg_q && ptr_q == '0)); // R2

    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (rst)
        cfg_q |-> (mask_q != '0 && ((mask_q + idx_t'(1)) & mask_q) == '0)); // R2

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!cfg_q && ptr_q == '0)); // R1

endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
    import rag_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int MAX_PAGES  = 8,
    parameter int REQ_DESC_B = 128,
    parameter int CMP_DESC_B = 32,
    parameter int MSG_DESC_B = 64,
    localparam int PFN_W     = ADDR_W - PAGE_SHIFT,
    localparam int PG_W      = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1,
    localparam int CNT_W     = $clog2(MAX_PAGES + 1),
    localparam int N_RING    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_en,
    input  logic              pt_we,
    input  logic [1:0]        pt_ring,
    input  logic [PG_W-1:0]   pt_slot,
    input  logic [PFN_W-1:0]  pt_pfn,
    input  logic              setup_en,
    input  logic [1:0]        setup_ring,
    input  logic [CNT_W-1:0]  setup_pages,
    input  logic              pop_en,
    input  logic [1:0]        pop_ring,
    input  logic              flush_en,
    input  logic [1:0]        flush_ring,
    input  logic [31:0]       req_prod_idx,
    input  logic [31:0]       msg_cons_idx,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_ring,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              st_prod_we,
    output logic              st_cons_we,
    output logic              st_log2_we,
    output logic [1:0]        st_ring,
    output logic [31:0]       st_idx,
    output logic [5:0]        st_log2
);

    logic              gate;
    logic              l_cfg      [N_RING];
    logic              l_setup_ok [N_RING];
    logic [LOG_W-1:0]  l_log2     [N_RING];
    idx_t              l_ptr      [N_RING];
    logic              l_pop_ok   [N_RING];
    logic [ADDR_W-1:0] l_addr     [N_RING];

    assign gate = !clr_en && !setup_en;

    for (genvar k = 0; k < N_RING; k++) begin : g_lane
        localparam int DB = (k == 0) ? REQ_DESC_B :
                            (k == 1) ? CMP_DESC_B : MSG_DESC_B;
        idx_t peer;
        assign peer = (k == 0) ? req_prod_idx :
                      (k == 2) ? msg_cons_idx : '0;

        rag_lane #(
            .KIND       (ring_e'(k)),
            .ADDR_W     (ADDR_W),
            .PAGE_SHIFT (PAGE_SHIFT),
            .MAX_PAGES  (MAX_PAGES),
            .DESC_BYTES (DB)
        ) u_lane (
            .clk           (clk),
            .rst           (rst),
            .clr           (clr_en),
            .setup_i       (!clr_en && setup_en && (setup_ring == 2'(k))),
            .setup_pages_i (setup_pages),
            .pt_we_i       (pt_we && (pt_ring == 2'(k))),
            .pt_slot_i     (pt_slot),
            .pt_pfn_i      (pt_pfn),
            .pop_i         (gate && pop_en && (pop_ring == 2'(k))),
            .flush_i       (gate && flush_en && (flush_ring == 2'(k))),
            .peer_idx_i    (peer),
            .cfg_o         (l_cfg[k]),
            .setup_ok_o    (l_setup_ok[k]),
            .new_log2_o    (l_log2[k]),
            .ptr_o         (l_ptr[k]),
            .pop_ok_o      (l_pop_ok[k]),
            .pop_addr_o    (l_addr[k])
        );
    end

    logic              rsp_v_d;
    logic              rsp_hit_d;
    logic [ADDR_W-1:0] rsp_addr_d;
    stat_wr_t          st_d;
    stat_wr_t          st_q;

    always_comb begin
        rsp_v_d    = gate && pop_en && (pop_ring != RING_NONE);
        rsp_hit_d  = 1'b0;
        rsp_addr_d = '0;
        for (int k = 0; k < N_RING; k++) begin
            if (rsp_v_d && pop_ring == 2'(k) && l_pop_ok[k]) begin
                rsp_hit_d  = 1'b1;
                rsp_addr_d = l_addr[k];
            end
        end
    end

    always_comb begin
        st_d = '0;
        for (int k = 0; k < N_RING; k++) begin
            if (l_setup_ok[k]) begin
                st_d.prod_we = 1'b1;
                st_d.cons_we = 1'b1;
                st_d.log2_we = 1'b1;
                st_d.ring    = ring_e'(k);
                st_d.log2    = l_log2[k];
            end else if (gate && flush_en && flush_ring == 2'(k) && l_cfg[k]) begin
                st_d.prod_we = (k != 0);
                st_d.cons_we = (k == 0);
                st_d.ring    = ring_e'(k);
                st_d.idx     = l_ptr[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ring  <= '0;
            rsp_addr  <= '0;
            st_q      <= '0;
        end else begin
            rsp_valid <= rsp_v_d;
            rsp_hit   <= rsp_hit_d;
            rsp_ring  <= pop_ring;
            rsp_addr  <= rsp_addr_d;
            st_q      <= st_d;
        end
    end

    assign st_prod_we = st_q.prod_we;
    assign st_cons_we = st_q.cons_we;
    assign st_log2_we = st_q.log2_we;
    assign st_ring    = st_q.ring;
    assign st_idx     = st_q.idx;
    assign st_log2    = st_q.log2;

    AST_SETUP_WINS: assert property (@(posedge clk) disable iff (rst)
        setup_en |=> !rsp_valid); // R10

    AST_CLR_SILENT: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> (!rsp_valid && !st_prod_we && !st_cons_we && !st_log2_we)); // R1

endmodule

// File: tb/sim_ring_addr_gen.sv
module sim_ring_addr_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        clr_en, pt_we, setup_en, pop_en, flush_en;
    logic [1:0]  pt_ring, setup_ring, pop_ring, flush_ring;
    logic [2:0]  pt_slot;
    logic [51:0] pt_pfn;
    logic [3:0]  setup_pages;
    logic [31:0] req_prod_idx, msg_cons_idx;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_ring;
    logic [63:0] rsp_addr;
    logic        st_prod_we, st_cons_we, st_log2_we;
    logic [1:0]  st_ring;
    logic [31:0] st_idx;
    logic [5:0]  st_log2;

    int n_run  = 0;
    int n_fail = 0;
    logic [51:0] mpt [3][8];

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_addr_gen u0 (
        .clk(clk), .rst(rst), .clr_en(clr_en),
        .pt_we(pt_we), .pt_ring(pt_ring), .pt_slot(pt_slot), .pt_pfn(pt_pfn),
        .setup_en(setup_en), .setup_ring(setup_ring), .setup_pages(setup_pages),
        .pop_en(pop_en), .pop_ring(pop_ring), .flush_en(flush_en), .flush_ring(flush_ring),
        .req_prod_idx(req_prod_idx), .msg_cons_idx(msg_cons_idx),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ring(rsp_ring), .rsp_addr(rsp_addr),
        .st_prod_we(st_prod_we), .st_cons_we(st_cons_we), .st_log2_we(st_log2_we),
        .st_ring(st_ring), .st_idx(st_idx), .st_log2(st_log2)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL all watchdog expired: actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_addr(input int ring, input int pages,
                                             input longint unsigned ptr);
        int desc, epp, slot;
        desc = (ring == 0) ? 128 : (ring == 1) ? 32 : 64;
        epp  = 4096 / desc;
        slot = int'(ptr % longint'(pages * epp));
        return {mpt[ring][slot / epp], 12'h000} + 64'(slot % epp) * 64'(desc);
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        clr_en = 0; pt_we = 0; setup_en = 0; pop_en = 0; flush_en = 0;
    endtask

    task automatic load_pt(input int ring, input int slot, input logic [51:0] pfn);
        pt_we = 1; pt_ring = 2'(ring); pt_slot = 3'(slot); pt_pfn = pfn;
        mpt[ring][slot] = pfn;
        cyc();
        idle();
    endtask

    task automatic do_setup(input int ring, input int pages);
        setup_en = 1; setup_ring = 2'(ring); setup_pages = 4'(pages);
        cyc();
        idle();
    endtask

    task automatic do_pop(input int ring);
        pop_en = 1; pop_ring = 2'(ring);
        cyc();
        idle();
    endtask

    task automatic do_flush(input int ring);
        flush_en = 1; flush_ring = 2'(ring);
        cyc();
        idle();
    endtask

    task automatic t_reset();
        chk("R1", "rsp_valid after reset", 64'(rsp_valid), 0);
        chk("R1", "status strobes after reset", {st_prod_we, st_cons_we, st_log2_we}, 0);
        req_prod_idx = 5;
        do_pop(0);
        chk("R1", "unconfigured pop valid", 64'(rsp_valid), 1);
        chk("R1", "unconfigured pop hit", 64'(rsp_hit), 0);
        chk("R1", "unconfigured pop addr", rsp_addr, 0);
        do_flush(0);
        chk("R1", "unconfigured flush no write", {st_prod_we, st_cons_we, st_log2_we}, 0);
    endtask

    task automatic t_bad_setup();
        do_setup(0, 3);
        chk("R2", "pages=3 rejected", {st_prod_we, st_cons_we, st_log2_we}, 0);
        do_setup(0, 0);
        chk("R2", "pages=0 rejected", {st_prod_we, st_cons_we, st_log2_we}, 0);
        do_pop(0);
        chk("R2", "ring still unconfigured", 64'(rsp_hit), 0);
    endtask

    task automatic t_req();
        load_pt(0, 0, 52'hABCDE);
        load_pt(0, 1, 52'h12345);
        do_setup(0, 2);
        chk("R2", "setup strobes", {st_prod_we, st_cons_we, st_log2_we}, 3'b111);
        chk("R2", "setup ring", 64'(st_ring), 0);
        chk("R2", "setup idx", 64'(st_idx), 0);
        chk("R2", "setup log2 req 2 pages", 64'(st_log2), 6);
        req_prod_idx = 0;
        do_pop(0);
        chk("R4", "equal indices no slot", {rsp_valid, rsp_hit}, 2'b10);
        chk("R4", "equal indices addr", rsp_addr, 0);
        req_prod_idx = 40;
        for (int i = 0; i < 40; i++) begin
            do_pop(0);
            chk("R3", $sformatf("req slot %0d hit", i), 64'(rsp_hit), 1);
            chk("R3", $sformatf("req slot %0d addr", i), rsp_addr, exp_addr(0, 2, i));
        end
        do_pop(0);
        chk("R4", "caught up no slot", 64'(rsp_hit), 0);
        do_flush(0);
        chk("R5", "flush strobes", {st_prod_we, st_cons_we, st_log2_we}, 3'b010);
        chk("R5", "flush idx", 64'(st_idx), 40);
        req_prod_idx = 70;
        for (int i = 40; i < 70; i++) begin
            do_pop(0);
            chk("R3", $sformatf("req wrap ptr %0d", i), rsp_addr, exp_addr(0, 2, i));
        end
        chk("R3", "last wrapped slot 5", rsp_addr, 64'hABCDE000 + 5 * 128);
    endtask

    task automatic t_cmp();
        load_pt(1, 0, 52'h777);
        do_setup(1, 1);
        chk("R2", "setup log2 cmp 1 page", 64'(st_log2), 7);
        for (int i = 0; i < 130; i++) begin
            do_pop(1);
            chk("R6", $sformatf("cmp pop %0d hit", i), 64'(rsp_hit), 1);
            chk("R6", $sformatf("cmp pop %0d addr", i), rsp_addr, exp_addr(1, 1, i));
        end
        do_flush(1);
        chk("R7", "cmp flush strobes", {st_prod_we, st_cons_we, st_log2_we}, 3'b100);
        chk("R7", "cmp flush idx", 64'(st_idx), 130);
        chk("R7", "cmp flush ring", 64'(st_ring), 1);
    endtask

    task automatic t_msg();
        load_pt(2, 0, 52'h4242);
        load_pt(2, 1, 52'h5151);
        do_setup(2, 2);
        chk("R2", "setup log2 msg 2 pages", 64'(st_log2), 7);
        msg_cons_idx = 0;
        for (int i = 0; i < 3; i++) begin
            do_pop(2);
            chk("R8", $sformatf("msg pop %0d hit", i), 64'(rsp_hit), 1);
            chk("R3", $sformatf("msg pop %0d addr", i), rsp_addr, exp_addr(2, 2, i));
        end
        do_flush(2);
        chk("R9", "msg flush strobes", {st_prod_we, st_cons_we, st_log2_we}, 3'b100);
        chk("R9", "msg flush idx", 64'(st_idx), 3);
        msg_cons_idx = 32'd3 - 32'd128;
        do_pop(2);
        chk("R8", "msg full refused", {rsp_valid, rsp_hit}, 2'b10);
        chk("R8", "msg full addr", rsp_addr, 0);
        msg_cons_idx = 32'd3 - 32'd127;
        do_pop(2);
        chk("R8", "msg room across wrap", 64'(rsp_hit), 1);
        chk("R8", "msg pointer held after refusal", rsp_addr, exp_addr(2, 2, 3));
    endtask

    task automatic t_prio();
        req_prod_idx = 71;
        setup_en = 1; setup_ring = 2'd1; setup_pages = 4'd1;
        pop_en = 1; pop_ring = 2'd0;
        flush_en = 1; flush_ring = 2'd0;
        cyc();
        idle();
        chk("R10", "pop dropped under setup", 64'(rsp_valid), 0);
        chk("R10", "setup write not flush", {st_prod_we, st_cons_we, st_log2_we}, 3'b111);
        chk("R10", "setup ring wins", 64'(st_ring), 1);
        do_pop(0);
        chk("R10", "req pointer unchanged", rsp_addr, exp_addr(0, 2, 70));
        do_pop(1);
        chk("R2", "cmp pointer zeroed by setup", rsp_addr, exp_addr(1, 1, 0));
    endtask

    task automatic t_clear();
        clr_en = 1;
        setup_en = 1; setup_ring = 2'd0; setup_pages = 4'd1;
        cyc();
        idle();
        for (int r = 0; r < 3; r++) for (int s = 0; s < 8; s++) mpt[r][s] = '0;
        chk("R1", "clear beats setup", {st_prod_we, st_cons_we, st_log2_we}, 0);
        do_pop(1);
        chk("R1", "cmp unconfigured after clear", 64'(rsp_hit), 0);
        do_flush(1);
        chk("R1", "flush after clear no write", {st_prod_we, st_cons_we, st_log2_we}, 0);
        do_setup(0, 1);
        req_prod_idx = 80;
        do_pop(0);
        do_pop(0);
        chk("R1", "page table zeroed hit", 64'(rsp_hit), 1);
        chk("R1", "page table zeroed addr", rsp_addr, 128);
    endtask

    initial begin
        for (int r = 0; r < 3; r++) for (int s = 0; s < 8; s++) mpt[r][s] = '0;
        idle();
        pt_ring = 0; pt_slot = 0; pt_pfn = 0;
        setup_ring = 0; setup_pages = 0; pop_ring = 0; flush_ring = 0;
        req_prod_idx = 0; msg_cons_idx = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        cyc();
        t_reset();
        t_bad_setup();
        t_req();
        t_cmp();
        t_msg();
        t_prio();
        t_clear();
        summary();
        $finish;
    end

endmodule